// File: doc/BRIEF.md
# Configurable Register Field Access Policy

This block holds one storage field of a memory-mapped register. A bus port drives it with an address-hit qualifier, write and read strobes, and write data. Parameters fix how a write changes the stored bits and whether a read has a side effect. They also set the access type (read-write, read-only, write-only, write-once, or readable write-once), the reset value with its defining mask, and an optional legal range for written values. Hardware logic can raise or drop individual bits through set and clear vectors, so the field also serves as a status register. The current content is always visible on `q_o` for the hardware that owns the field.

An error output pulses when a bus write is refused. A write is refused when its value falls outside the legal range or when a write-once lock has already been spent. Address decoding, bus protocol and packing of several fields into one word are left to the surrounding register file.

Top module: `field_policy_reg`

## Requirements
- R1: After reset, bit positions set in `RST_MASK` hold the matching bit of `RST_VAL`, and all other bit positions hold 0.
- R2: With the plain write mode, an accepted write stores `wdata_i` unchanged. A write strobe without `hit_i` has no effect. The stored value appears on `q_o` one cycle after the strobe, and on `rdata_o` for readable types.
- R3: The bitwise write modes act per bit against the write data: one-clears gives q&~d, one-sets gives q|d, one-toggles gives q^d, zero-clears gives q&d, zero-sets gives q|~d, zero-toggles gives q^~d.
- R4: The clear-all write mode zeroes every bit on any accepted write, and the set-all write mode drives every bit to 1.
- R5: Read action clear zeroes the field, and read action set drives it to all ones, in the cycle after a hit read. The read itself returns the value from before the side effect. When a write and a read land in the same cycle, the write result is stored.
- R6: With no read action, a read leaves the field unchanged.
- R7: In write-once access, only the first accepted write after reset changes the field. Each later write is ignored and raises the error pulse. Read data is 0.
- R8: In readable write-once access, read data returns the stored content. A write rejected by the range check does not spend the lock.
- R9: In read-only access, bus writes never change the field and never raise the error pulse.
- R10: In write-only access, read data is always 0, while `q_o` still carries the stored content.
- R11: With the range check enabled, a write below `MIN_VAL` or above `MAX_VAL` leaves the field unchanged and raises the error pulse. Writes equal to either bound are accepted.
- R12: Hardware set and clear bits apply after any bus update. A bit set by hardware ends up at 1 even when a bus clear or a hardware clear hits it in the same cycle.
- R13: `err_o` is high for exactly the one cycle after each rejected write, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hit_i | input | 1 | Address decode selects this field |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | WIDTH | Write data |
| hw_set_i | input | WIDTH | Hardware per-bit set |
| hw_clr_i | input | WIDTH | Hardware per-bit clear |
| rdata_o | output | WIDTH | Read data (0 for non-readable types) |
| q_o | output | WIDTH | Stored field content |
| err_o | output | 1 | One-cycle pulse after a rejected write |

## Verification
The hardest situations to reach are collisions: a bus clear, a hardware clear and a hardware set all on the same bit in the same edge, and a read side effect meeting a write in the same cycle. The bench instantiates one field per mode and access type on a shared bus. Every instance therefore sees the same collision cycles, including writes exactly at and just beyond the range bounds. A write-once field sees an out-of-range first attempt, a good write and a later refused write in sequence, so the lock and range paths interact.

// File: rtl/fp_pkg.sv
package fp_pkg;
  typedef enum logic [3:0] {
    WM_PLAIN, WM_ONE_CLR, WM_ONE_SET, WM_ONE_TGL,
    WM_ZERO_CLR, WM_ZERO_SET, WM_ZERO_TGL, WM_CLR_ALL, WM_SET_ALL
  } wmode_e;

  typedef enum logic [1:0] {RA_NONE, RA_CLEAR, RA_SET} ract_e;

  typedef enum logic [2:0] {AC_RW, AC_RO, AC_WO, AC_W1, AC_RW1} access_e;

  function automatic bit acc_readable(access_e a);
    return (a == AC_RW) || (a == AC_RO) || (a == AC_RW1);
  endfunction

  function automatic bit acc_writable(access_e a);
    return a != AC_RO;
  endfunction

  function automatic bit acc_once(access_e a);
    return (a == AC_W1) || (a == AC_RW1);
  endfunction
endpackage

// File: rtl/fp_write_mod.sv
module fp_write_mod
  import fp_pkg::*;
#(
  parameter int     WIDTH = 8,
  parameter wmode_e WMODE = WM_PLAIN
) (
  input  logic [WIDTH-1:0] old_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] new_o
);
  if (WMODE == WM_ONE_CLR) begin : g_one_clr
    assign new_o = old_i & ~wdata_i;
  end else if (WMODE == WM_ONE_SET) begin : g_one_set
    assign new_o = old_i | wdata_i;
  end else if (WMODE == WM_ONE_TGL) begin : g_one_tgl
    assign new_o = old_i ^ wdata_i;
  end else if (WMODE == WM_ZERO_CLR) begin : g_zero_clr
    assign new_o = old_i & wdata_i;
  end else if (WMODE == WM_ZERO_SET) begin : g_zero_set
    assign new_o = old_i | ~wdata_i;
  end else if (WMODE == WM_ZERO_TGL) begin : g_zero_tgl
    assign new_o = old_i ^ ~wdata_i;
  end else if (WMODE == WM_CLR_ALL) begin : g_clr_all
    assign new_o = '0;
  end else if (WMODE == WM_SET_ALL) begin : g_set_all
    assign new_o = '1;
  end else begin : g_plain
    assign new_o = wdata_i;
  end
endmodule

// File: rtl/fp_read_act.sv
module fp_read_act
  import fp_pkg::*;
#(
  parameter int    WIDTH = 8,
  parameter ract_e RACT  = RA_NONE
) (
  input  logic [WIDTH-1:0] cur_i,
  output logic [WIDTH-1:0] nxt_o
);
  if (RACT == RA_CLEAR) begin : g_clear
    assign nxt_o = '0;
  end else if (RACT == RA_SET) begin : g_set
    assign nxt_o = '1;
  end else begin : g_none
    assign nxt_o = cur_i;
  end
endmodule

// File: rtl/fp_write_gate.sv
module fp_write_gate
  import fp_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter access_e          ACCESS   = AC_RW,
  parameter bit               RANGE_EN = 1'b0,
  parameter logic [WIDTH-1:0] MIN_VAL  = 8'h01,
  parameter logic [WIDTH-1:0] MAX_VAL  = 8'hFE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_fire_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic             accept_o,
  output logic             err_o
);
  localparam bit WRITABLE = acc_writable(ACCESS);
  localparam bit ONCE     = acc_once(ACCESS);

  logic range_ok, used_q, reject, err_q;

  if (RANGE_EN) begin : g_range
    assign range_ok = (wdata_i >= MIN_VAL) && (wdata_i <= MAX_VAL);
  end else begin : g_no_range
    assign range_ok = 1'b1;
  end

  assign accept_o = wr_fire_i && WRITABLE && range_ok && !used_q;
  assign reject   = wr_fire_i && WRITABLE && (!range_ok || used_q);

  if (ONCE) begin : g_lock
    // lock is spent only by a write that was actually taken
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       used_q <= 1'b0;
      else if (accept_o) used_q <= 1'b1;
    end

    a_r7_lock_rejects: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_fire_i && used_q) |=> (err_o && $stable(used_q)));
  end else begin : g_no_lock
    assign used_q = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= reject;
  end
  assign err_o = err_q;
endmodule

// File: rtl/field_policy_reg.sv
module field_policy_reg
  import fp_pkg::*;
#(
  parameter int               WIDTH    = 8,
  parameter logic [WIDTH-1:0] RST_VAL  = '0,
  parameter logic [WIDTH-1:0] RST_MASK = '1,
  parameter wmode_e           WMODE    = WM_PLAIN,
  parameter ract_e            RACT     = RA_NONE,
  parameter access_e          ACCESS   = AC_RW,
  parameter bit               RANGE_EN = 1'b0,
  parameter logic [WIDTH-1:0] MIN_VAL  = 8'h01,
  parameter logic [WIDTH-1:0] MAX_VAL  = 8'hFE
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hit_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [WIDTH-1:0] hw_set_i,
  input  logic [WIDTH-1:0] hw_clr_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic [WIDTH-1:0] q_o,
  output logic             err_o
);
  localparam logic [WIDTH-1:0] RST_Q = RST_VAL & RST_MASK; // undefined bits load 0
  localparam bit READABLE = acc_readable(ACCESS);
  localparam bit HAS_RACT = (RACT != RA_NONE);

  logic             wr_fire, rd_fire, accept;
  logic [WIDTH-1:0] q_q, wm_val, ra_val, base, nxt;

  assign wr_fire = hit_i && wr_i;
  assign rd_fire = hit_i && rd_i;

  fp_write_gate #(
    .WIDTH(WIDTH), .ACCESS(ACCESS), .RANGE_EN(RANGE_EN),
    .MIN_VAL(MIN_VAL), .MAX_VAL(MAX_VAL)
  ) u_gate (
    .clk_i, .rst_ni, .wr_fire_i(wr_fire), .wdata_i,
    .accept_o(accept), .err_o
  );

  fp_write_mod #(.WIDTH(WIDTH), .WMODE(WMODE)) u_wmod (
    .old_i(q_q), .wdata_i, .new_o(wm_val)
  );

  fp_read_act #(.WIDTH(WIDTH), .RACT(RACT)) u_ract (
    .cur_i(q_q), .nxt_o(ra_val)
  );

  // bus write beats read side effect; hw set beats every clear
  always_comb begin
    if (accept)                                base = wm_val;
    else if (rd_fire && READABLE && HAS_RACT)  base = ra_val;
    else                                       base = q_q;
    nxt = (base & ~hw_clr_i) | hw_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= RST_Q;
    else         q_q <= nxt;
  end

  assign q_o     = q_q;
  assign rdata_o = READABLE ? q_q : '0;

  a_r12_hw_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|hw_set_i) |=> ((q_q & $past(hw_set_i)) == $past(hw_set_i)));

  a_r13_err_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_fire));

  if (ACCESS == AC_RO) begin : g_chk_ro
    a_r9_ro_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_fire && !rd_fire && hw_set_i == '0 && hw_clr_i == '0) |=> ($stable(q_q) && !err_o));
  end

  if (RANGE_EN) begin : g_chk_range
    a_r11_out_of_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_fire && !rd_fire && hw_set_i == '0 && hw_clr_i == '0 &&
       (wdata_i < MIN_VAL || wdata_i > MAX_VAL)) |=> ($stable(q_q) && err_o));
  end

  if (RACT == RA_CLEAR && READABLE) begin : g_chk_rclr
    a_r5_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_fire && !wr_fire && hw_set_i == '0) |=> (q_q == '0));
  end

  if (RACT == RA_NONE) begin : g_chk_rnone
    a_r6_read_keeps: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_fire && !wr_fire && hw_set_i == '0 && hw_clr_i == '0) |=> $stable(q_q));
  end
endmodule

// File: tb/field_policy_reg_test.sv
`timescale 1ns/1ps
module field_policy_reg_test;
  import fp_pkg::*;

  localparam int N = 15;

  typedef struct packed {
    wmode_e     wm;
    ract_e      ra;
    access_e    ac;
    logic       rng;
    logic [7:0] rv;
    logic [7:0] rm;
  } cfg_t;

  function automatic cfg_t cfg_of(int i);
    cfg_t c;
    c.wm = WM_PLAIN; c.ra = RA_NONE; c.ac = AC_RW; c.rng = 1'b0;
    c.rv = 8'h3C; c.rm = 8'hFF;
    if (i == 0) begin c.rng = 1'b1; c.rv = 8'hA5; c.rm = 8'h0F; end
    else if (i <= 8) c.wm = wmode_e'(4'(i));
    else if (i == 9)  c.ra = RA_CLEAR;
    else if (i == 10) c.ra = RA_SET;
    else if (i == 11) c.ac = AC_W1;
    else if (i == 12) begin c.ac = AC_RW1; c.rng = 1'b1; end
    else if (i == 13) begin c.ac = AC_RO; c.rm = 8'hF0; end
    else              c.ac = AC_WO;
    return c;
  endfunction

  function automatic string tag_of(int i);
    if (i == 0)  return "R2";
    if (i <= 6)  return "R3";
    if (i <= 8)  return "R4";
    if (i <= 10) return "R5";
    if (i == 11) return "R7";
    if (i == 12) return "R8";
    if (i == 13) return "R9";
    return "R10";
  endfunction

  function automatic logic [7:0] wmod(wmode_e m, logic [7:0] q, logic [7:0] d);
    case (m)
      WM_ONE_CLR:  return q & ~d;
      WM_ONE_SET:  return q | d;
      WM_ONE_TGL:  return q ^ d;
      WM_ZERO_CLR: return q & d;
      WM_ZERO_SET: return q | ~d;
      WM_ZERO_TGL: return q ^ ~d;
      WM_CLR_ALL:  return 8'h00;
      WM_SET_ALL:  return 8'hFF;
      default:     return d;
    endcase
  endfunction

  logic clk = 1'b0, rst_n = 1'b0;
  logic hit = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, hw_set = '0, hw_clr = '0;
  logic [7:0] q_a [N];
  logic [7:0] rd_a [N];
  logic       err_a [N];

  always #5 clk = ~clk;

  field_policy_reg #(
    .WIDTH(8), .RST_VAL(8'hA5), .RST_MASK(8'h0F), .WMODE(WM_PLAIN), .RACT(RA_NONE),
    .ACCESS(AC_RW), .RANGE_EN(1'b1), .MIN_VAL(8'h10), .MAX_VAL(8'hC0)
  ) uut (
    .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
    .hw_set_i(hw_set), .hw_clr_i(hw_clr), .rdata_o(rd_a[0]), .q_o(q_a[0]), .err_o(err_a[0])
  );

  for (genvar i = 1; i < N; i++) begin : g_dut
    localparam cfg_t C = cfg_of(i);
    field_policy_reg #(
      .WIDTH(8), .RST_VAL(C.rv), .RST_MASK(C.rm), .WMODE(C.wm), .RACT(C.ra),
      .ACCESS(C.ac), .RANGE_EN(C.rng), .MIN_VAL(8'h10), .MAX_VAL(8'hC0)
    ) u_f (
      .clk_i(clk), .rst_ni(rst_n), .hit_i(hit), .wr_i(wr), .rd_i(rd), .wdata_i(wdata),
      .hw_set_i(hw_set), .hw_clr_i(hw_clr), .rdata_o(rd_a[i]), .q_o(q_a[i]), .err_o(err_a[i])
    );
  end

  typedef struct {
    int         due;
    int         idx;
    int         kind; // 0 q, 1 rdata, 2 err
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t      sb[$];
  int         ncount = 0;
  int         checks = 0;
  int         fails  = 0;
  bit         done   = 1'b0;
  logic [7:0] m_q [N];
  bit         m_lock [N];

  // monitor: compare every item due at this falling edge
  always @(negedge clk) begin
    ncount++;
    while (sb.size() > 0 && sb[0].due == ncount) begin
      item_t it;
      logic [7:0] act;
      it = sb.pop_front();
      case (it.kind)
        0:       act = q_a[it.idx];
        1:       act = rd_a[it.idx];
        default: act = {7'b0, err_a[it.idx]};
      endcase
      checks++;
      if (act !== it.exp) begin
        fails++;
        $display("FAIL %s inst %0d kind %0d: actual %h expected %h", it.tag, it.idx, it.kind, act, it.exp);
      end
    end
  end

  task automatic step(bit h, bit w, bit r, logic [7:0] wd, logic [7:0] hs, logic [7:0] hc, string tag);
    @(negedge clk);
    #1;
    hit = h; wr = w; rd = r; wdata = wd; hw_set = hs; hw_clr = hc;
    for (int i = 0; i < N; i++) begin
      cfg_t c;
      bit rdbl, wrbl, once, rok, acc, er;
      logic [7:0] b;
      string t;
      c    = cfg_of(i);
      rdbl = c.ac inside {AC_RW, AC_RO, AC_RW1};
      wrbl = c.ac != AC_RO;
      once = c.ac inside {AC_W1, AC_RW1};
      rok  = !c.rng || (wd >= 8'h10 && wd <= 8'hC0);
      acc  = h && w && wrbl && rok && !(once && m_lock[i]);
      er   = h && w && wrbl && (!rok || (once && m_lock[i]));
      b    = m_q[i];
      if (acc) b = wmod(c.wm, m_q[i], wd);
      else if (h && r && rdbl && c.ra == RA_CLEAR) b = 8'h00;
      else if (h && r && rdbl && c.ra == RA_SET)   b = 8'hFF;
      b = (b & ~hc) | hs;
      if (acc && once) m_lock[i] = 1'b1;
      m_q[i] = b;
      t = (tag != "") ? tag : tag_of(i);
      sb.push_back('{ncount + 1, i, 0, b, t});
      sb.push_back('{ncount + 1, i, 1, rdbl ? b : 8'h00, t});
      sb.push_back('{ncount + 1, i, 2, {7'b0, er}, (tag != "") ? tag : "R13"});
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      cfg_t c;
      c = cfg_of(i);
      m_q[i] = c.rv & c.rm;
      m_lock[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    step(0, 0, 0, 8'h00, 8'h00, 8'h00, "R1");  // reset values, masked bits only
    step(1, 1, 0, 8'h05, 8'h00, 8'h00, "");    // below range: RW1 lock not spent
    step(1, 1, 0, 8'h5A, 8'h00, 8'h00, "");    // first good write
    step(1, 0, 1, 8'h00, 8'h00, 8'h00, "");    // read side effects
    step(1, 0, 1, 8'h00, 8'h00, 8'h00, "R6");  // repeat read
    step(1, 1, 0, 8'hE7, 8'h00, 8'h00, "");    // above range, lock refuses
    step(1, 1, 0, 8'h0F, 8'h00, 8'h00, "R11");
    step(1, 1, 0, 8'h10, 8'h00, 8'h00, "R11");
    step(1, 1, 0, 8'hC0, 8'h00, 8'h00, "R11");
    step(1, 1, 0, 8'hC1, 8'h00, 8'h00, "R11");
    step(1, 1, 0, 8'hFF, 8'h81, 8'h03, "R12"); // hw set vs bus and hw clear
    step(0, 0, 0, 8'h00, 8'h00, 8'h0F, "R12");
    step(1, 1, 1, 8'h66, 8'h00, 8'h00, "R5");  // write and read together
    step(0, 1, 0, 8'h33, 8'h00, 8'h00, "R2");  // strobe without hit
    step(1, 1, 0, 8'h2D, 8'h00, 8'h00, "");
    step(1, 0, 1, 8'h00, 8'h00, 8'h00, "");
    step(0, 0, 0, 8'h00, 8'h00, 8'h00, "");
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R13 scoreboard: actual %0d pending expected 0", sb.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule